// File: doc/BRIEF.md
# Translation Buffer with Access Permissions

This block translates 64-bit virtual addresses into 40-bit physical addresses for pages of 4 KiB. It keeps eight recently used translations in a fully associative store. Every lookup compares the page number against all eight stored tags in the same cycle. The answer is combinational: either a translated address or one of two exceptions, protection or page fault. When a lookup hits, the matching entry's usage counter and modified flag change at the next clock edge.

A refill port writes one whole entry at a chosen slot. Software outside this block walks the page tables, picks the victim slot and drives that port. The translated address is also given out already cut into the fields that a cache needs: memory line, cache line index, word within the line, and access size. On a hit the block also reports the entry's modified flag and usage count as they stood before the access. This lets the caller see the bookkeeping that the access is about to change.

Top module: `xlat_buffer`

## Requirements
- R1: On a hit, `pa` equals the entry's 28-bit physical page number followed by `lk_vaddr[11:0]` unchanged. The page number is compared using `lk_vaddr[63:12]`. When there is no hit, `pa` is zero.
- R2: The field outputs equal slices of `pa`: `pa_mem_line` = `pa[39:14]`, `pa_line_idx` = `pa[13:6]`, `pa_word` = `pa[5:2]`, `pa_size` = `pa[1:0]`.
- R3: `hit` is high when `lk_valid` is high and some entry has the valid bit set, a tag equal to all 52 page-number bits, and at least one of its read or write permission bits set. The type of access (read or write) plays no part in this decision.
- R4: `page_fault` is high when `lk_valid` is high and no valid entry's tag equals the page number.
- R5: `prot_fault` is high when `lk_valid` is high and the selected matching entry has both permission bits clear.
- R6: While `lk_valid` is high, exactly one of `hit`, `prot_fault` and `page_fault` is high. While `lk_valid` is low, all three are low.
- R7: Each hit adds one to the entry's 2-bit usage count at the next edge. The count stops at 3. `hit_ref` shows the count from before the access.
- R8: A hit with `lk_write`=1 sets the entry's modified flag at the next edge. A read hit leaves the flag unchanged. `hit_dirty` shows the flag from before the access.
- R9: A lookup that raises either exception changes the state of no entry.
- R10: A refill writes valid, read, write, tag and page number into slot `fill_idx`, and clears that slot's modified flag and usage count. If a hit update targets the same slot in the same cycle, the refill wins.
- R11: When several valid entries carry the same tag, the lowest-numbered slot is the one selected. That slot alone decides hit or protection fault, and only that slot is updated.
- R12: After reset every entry is invalid, so any lookup gives a page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_vaddr | input | 64 | Virtual address to translate |
| fill_en | input | 1 | Write one entry this cycle |
| fill_idx | input | 3 | Slot to write |
| fill_valid | input | 1 | Valid bit for the new entry |
| fill_rd | input | 1 | Read permission for the new entry |
| fill_wr | input | 1 | Write permission for the new entry |
| fill_vpn | input | 52 | Tag (virtual page number) for the new entry |
| fill_ppn | input | 28 | Physical page number for the new entry |
| hit | output | 1 | Translation succeeded |
| prot_fault | output | 1 | Matching entry grants no access |
| page_fault | output | 1 | No valid entry matches |
| pa | output | 40 | Translated physical address |
| pa_mem_line | output | 26 | Memory line number |
| pa_line_idx | output | 8 | Cache line index |
| pa_word | output | 4 | Word offset within the line |
| pa_size | output | 2 | Access size bits |
| hit_dirty | output | 1 | Modified flag of the hit entry before the access |
| hit_ref | output | 2 | Usage count of the hit entry before the access |

## Verification
The hardest cases to reach from the ports are the ones where the lookup logic and the refill port disagree about the same entry. One is two slots holding one tag with different permissions. The other is a refill and a write hit landing on the same slot in the same cycle. The stimulus builds both directly. It loads a no-permission slot below a readable slot with the same tag, issues write lookups against them, then invalidates the lower slot. The readable slot's reported flag and count then show whether the faulting accesses or the lost update touched it. The saturation of the usage count is reached by running several hits in a row on one page through the vector table.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
// Shared types for the translation buffer.
package xlat_pkg;
    // Result of one lookup cycle.
    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_PROT  = 2'd2,
        OUT_PGFLT = 2'd3
    } outcome_e;
endpackage

// File: rtl/xlat_entry.sv
`timescale 1ns/1ps
// One translation slot: tag, page number, permissions and usage state.
// Assumes the parent never asserts fill_we and expects upd_en to take effect
// in the same cycle; the refill takes precedence.
module xlat_entry #(
    parameter int VPN_W    = 52,
    parameter int PPN_W    = 28,
    parameter int REF_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fill_we,
    input  logic                fill_valid,
    input  logic                fill_rd,
    input  logic                fill_wr,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic                upd_en,
    input  logic                upd_write,
    input  logic [VPN_W-1:0]    look_vpn,
    output logic                valid,
    output logic                tag_hit,
    output logic                perm_ok,
    output logic                dirty,
    output logic [REF_BITS-1:0] ref_cnt,
    output logic [PPN_W-1:0]    ppn
);
    localparam logic [REF_BITS-1:0] REF_MAX = '1;

    logic             rd_q;
    logic             wr_q;
    logic [VPN_W-1:0] vpn_q;

    // Slot state: reset, refill, or usage update on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            dirty   <= 1'b0;
            ref_cnt <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            vpn_q   <= '0;
            ppn     <= '0;
        end else if (fill_we) begin
            valid   <= fill_valid;
            dirty   <= 1'b0;
            ref_cnt <= '0;
            rd_q    <= fill_rd;
            wr_q    <= fill_wr;
            vpn_q   <= fill_vpn;
            ppn     <= fill_ppn;
        end else if (upd_en) begin
            if (ref_cnt != REF_MAX) begin
                ref_cnt <= ref_cnt + 1'b1;
            end
            if (upd_write) begin
                dirty <= 1'b1;
            end
        end
    end

    // Tag comparison and permission summary.
    always_comb begin
        tag_hit = valid && (vpn_q == look_vpn);
        perm_ok = rd_q || wr_q;
    end
endmodule

// File: rtl/xlat_select.sv
`timescale 1ns/1ps
// Priority selector: picks the lowest-numbered slot whose tag matches and
// forwards its fields. Assumes tag_hit already includes the valid bit.
module xlat_select #(
    parameter int N        = 8,
    parameter int PPN_W    = 28,
    parameter int REF_BITS = 2,
    localparam int IDX_W   = $clog2(N)
) (
    input  logic [N-1:0]                tag_hit,
    input  logic [N-1:0]                perm_ok,
    input  logic [N-1:0]                dirty,
    input  logic [N-1:0][REF_BITS-1:0]  ref_cnt,
    input  logic [N-1:0][PPN_W-1:0]     ppn,
    output logic                        any_match,
    output logic [IDX_W-1:0]            sel_idx,
    output logic                        sel_perm,
    output logic                        sel_dirty,
    output logic [REF_BITS-1:0]         sel_ref,
    output logic [PPN_W-1:0]            sel_ppn
);
    // Scan from the top down so the lowest matching slot is written last.
    always_comb begin
        any_match = 1'b0;
        sel_idx   = '0;
        sel_perm  = 1'b0;
        sel_dirty = 1'b0;
        sel_ref   = '0;
        sel_ppn   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (tag_hit[i]) begin
                any_match = 1'b1;
                sel_idx   = IDX_W'(i);
                sel_perm  = perm_ok[i];
                sel_dirty = dirty[i];
                sel_ref   = ref_cnt[i];
                sel_ppn   = ppn[i];
            end
        end
    end
endmodule

// File: rtl/xlat_split.sv
`timescale 1ns/1ps
// Cuts a physical address into memory line, cache line index, word and size.
// Assumes SIZE_W < WORD_LSB_END < LINE_LSB_END < PA_W.
module xlat_split #(
    parameter int PA_W         = 40,
    parameter int LINE_LSB_END = 14,
    parameter int WORD_LSB_END = 6,
    parameter int SIZE_W       = 2
) (
    input  logic [PA_W-1:0]                      pa,
    output logic [PA_W-LINE_LSB_END-1:0]         mem_line,
    output logic [LINE_LSB_END-WORD_LSB_END-1:0] line_idx,
    output logic [WORD_LSB_END-SIZE_W-1:0]       word,
    output logic [SIZE_W-1:0]                    size
);
    // Field slicing.
    always_comb begin
        mem_line = pa[PA_W-1:LINE_LSB_END];
        line_idx = pa[LINE_LSB_END-1:WORD_LSB_END];
        word     = pa[WORD_LSB_END-1:SIZE_W];
        size     = pa[SIZE_W-1:0];
    end
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
// Fully associative translation buffer with permission checks.
// A lookup resolves combinationally; usage state of the selected slot updates
// at the next edge, and only when the lookup hits. A refill writes one slot.
// Assumes one lookup per cycle and that inputs are stable around the edge.
module xlat_buffer #(
    parameter int NUM_ENTRIES = 8,
    parameter int VA_WIDTH    = 64,
    parameter int PA_WIDTH    = 40,
    parameter int PAGE_BITS   = 12,
    parameter int REF_BITS    = 2,
    parameter int MEM_LSB     = 14,
    parameter int LINE_LSB    = 6,
    parameter int SIZE_BITS   = 2,
    localparam int VPN_W      = VA_WIDTH - PAGE_BITS,
    localparam int PPN_W      = PA_WIDTH - PAGE_BITS,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lk_valid,
    input  logic                         lk_write,
    input  logic [VA_WIDTH-1:0]          lk_vaddr,
    input  logic                         fill_en,
    input  logic [IDX_W-1:0]             fill_idx,
    input  logic                         fill_valid,
    input  logic                         fill_rd,
    input  logic                         fill_wr,
    input  logic [VPN_W-1:0]             fill_vpn,
    input  logic [PPN_W-1:0]             fill_ppn,
    output logic                         hit,
    output logic                         prot_fault,
    output logic                         page_fault,
    output logic [PA_WIDTH-1:0]          pa,
    output logic [PA_WIDTH-MEM_LSB-1:0]  pa_mem_line,
    output logic [MEM_LSB-LINE_LSB-1:0]  pa_line_idx,
    output logic [LINE_LSB-SIZE_BITS-1:0] pa_word,
    output logic [SIZE_BITS-1:0]         pa_size,
    output logic                         hit_dirty,
    output logic [REF_BITS-1:0]          hit_ref
);
    import xlat_pkg::*;

    logic [VPN_W-1:0]                      look_vpn;
    logic [NUM_ENTRIES-1:0]                valid_vec;
    logic [NUM_ENTRIES-1:0]                tag_hit_vec;
    logic [NUM_ENTRIES-1:0]                perm_vec;
    logic [NUM_ENTRIES-1:0]                dirty_vec;
    logic [NUM_ENTRIES-1:0][REF_BITS-1:0]  ref_vec;
    logic [NUM_ENTRIES-1:0][PPN_W-1:0]     ppn_vec;
    logic [NUM_ENTRIES-1:0]                fill_we_vec;
    logic [NUM_ENTRIES-1:0]                upd_vec;

    logic                 any_match;
    logic [IDX_W-1:0]     sel_idx;
    logic                 sel_perm;
    logic                 sel_dirty;
    logic [REF_BITS-1:0]  sel_ref;
    logic [PPN_W-1:0]     sel_ppn;
    outcome_e             outcome;

    assign look_vpn = lk_vaddr[VA_WIDTH-1:PAGE_BITS];

    // One slot per entry, each with its own refill and update strobe.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign fill_we_vec[g] = fill_en && (fill_idx == IDX_W'(g));
        assign upd_vec[g]     = (outcome == OUT_HIT) && (sel_idx == IDX_W'(g));

        xlat_entry #(
            .VPN_W    (VPN_W),
            .PPN_W    (PPN_W),
            .REF_BITS (REF_BITS)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_we    (fill_we_vec[g]),
            .fill_valid (fill_valid),
            .fill_rd    (fill_rd),
            .fill_wr    (fill_wr),
            .fill_vpn   (fill_vpn),
            .fill_ppn   (fill_ppn),
            .upd_en     (upd_vec[g]),
            .upd_write  (lk_write),
            .look_vpn   (look_vpn),
            .valid      (valid_vec[g]),
            .tag_hit    (tag_hit_vec[g]),
            .perm_ok    (perm_vec[g]),
            .dirty      (dirty_vec[g]),
            .ref_cnt    (ref_vec[g]),
            .ppn        (ppn_vec[g])
        );
    end

    xlat_select #(
        .N        (NUM_ENTRIES),
        .PPN_W    (PPN_W),
        .REF_BITS (REF_BITS)
    ) u_select (
        .tag_hit   (tag_hit_vec),
        .perm_ok   (perm_vec),
        .dirty     (dirty_vec),
        .ref_cnt   (ref_vec),
        .ppn       (ppn_vec),
        .any_match (any_match),
        .sel_idx   (sel_idx),
        .sel_perm  (sel_perm),
        .sel_dirty (sel_dirty),
        .sel_ref   (sel_ref),
        .sel_ppn   (sel_ppn)
    );

    // Classify the lookup: idle, hit, protection fault or page fault.
    always_comb begin
        if (!lk_valid) begin
            outcome = OUT_IDLE;
        end else if (!any_match) begin
            outcome = OUT_PGFLT;
        end else if (!sel_perm) begin
            outcome = OUT_PROT;
        end else begin
            outcome = OUT_HIT;
        end
    end

    // Drive result outputs from the outcome and selected slot.
    always_comb begin
        hit        = (outcome == OUT_HIT);
        prot_fault = (outcome == OUT_PROT);
        page_fault = (outcome == OUT_PGFLT);
        pa         = hit ? {sel_ppn, lk_vaddr[PAGE_BITS-1:0]} : '0;
        hit_dirty  = hit && sel_dirty;
        hit_ref    = hit ? sel_ref : '0;
    end

    xlat_split #(
        .PA_W         (PA_WIDTH),
        .LINE_LSB_END (MEM_LSB),
        .WORD_LSB_END (LINE_LSB),
        .SIZE_W       (SIZE_BITS)
    ) u_split (
        .pa       (pa),
        .mem_line (pa_mem_line),
        .line_idx (pa_line_idx),
        .word     (pa_word),
        .size     (pa_size)
    );
endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
// Property checker for xlat_buffer, attached by bind. Watches the ports and
// the per-slot state vectors; drives nothing.
module xlat_buffer_chk #(
    parameter int N        = 8,
    parameter int VA_W     = 64,
    parameter int PA_W     = 40,
    parameter int PAGE_W   = 12,
    parameter int REF_BITS = 2,
    localparam int IDX_W   = $clog2(N)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        lk_valid,
    input logic                        lk_write,
    input logic [VA_W-1:0]             lk_vaddr,
    input logic                        fill_en,
    input logic [IDX_W-1:0]            fill_idx,
    input logic                        hit,
    input logic                        prot_fault,
    input logic                        page_fault,
    input logic [PA_W-1:0]             pa,
    input logic [REF_BITS-1:0]         hit_ref,
    input logic [IDX_W-1:0]            sel_idx,
    input logic [N-1:0]                valid_vec,
    input logic [N-1:0]                dirty_vec,
    input logic [N-1:0][REF_BITS-1:0]  ref_vec
);
    localparam logic [REF_BITS-1:0] REF_MAX = '1;
    logic [REF_BITS-1:0] ref_plus;
    assign ref_plus = hit_ref + 1'b1;

    // R6: one outcome per requested lookup.
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({hit, prot_fault, page_fault}) == 1);

    // R6: silent when no lookup.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !hit && !prot_fault && !page_fault);

    // R1: page offset passes through.
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> pa[PAGE_W-1:0] == lk_vaddr[PAGE_W-1:0]);

    // R9: exceptions leave all slot state untouched.
    a_r9_exc_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_fault || page_fault) && !fill_en |=>
            $stable(valid_vec) && $stable(dirty_vec) && $stable(ref_vec));

    // R8: write hit marks the selected slot modified.
    a_r8_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit && lk_write && !fill_en |=> dirty_vec[$past(sel_idx)]);

    // R7: usage count of the selected slot steps by one below saturation.
    a_r7_ref_step: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !fill_en && hit_ref != REF_MAX |=>
            ref_vec[$past(sel_idx)] == $past(ref_plus));

    // R10: refill clears usage state of the written slot.
    a_r10_fill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> !dirty_vec[$past(fill_idx)] && ref_vec[$past(fill_idx)] == '0);
endmodule

bind xlat_buffer xlat_buffer_chk #(
    .N        (NUM_ENTRIES),
    .VA_W     (VA_WIDTH),
    .PA_W     (PA_WIDTH),
    .PAGE_W   (PAGE_BITS),
    .REF_BITS (REF_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_write   (lk_write),
    .lk_vaddr   (lk_vaddr),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .hit        (hit),
    .prot_fault (prot_fault),
    .page_fault (page_fault),
    .pa         (pa),
    .hit_ref    (hit_ref),
    .sel_idx    (sel_idx),
    .valid_vec  (valid_vec),
    .dirty_vec  (dirty_vec),
    .ref_vec    (ref_vec)
);

// File: tb/test_xlat_buffer.sv
`timescale 1ns/1ps
// Self-checking bench for xlat_buffer: vector table, then directed cases.
module test_xlat_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [63:0] lk_vaddr = '0;
    logic        fill_en = 1'b0;
    logic [2:0]  fill_idx = '0;
    logic        fill_valid = 1'b0;
    logic        fill_rd = 1'b0;
    logic        fill_wr = 1'b0;
    logic [51:0] fill_vpn = '0;
    logic [27:0] fill_ppn = '0;
    logic        hit, prot_fault, page_fault;
    logic [39:0] pa;
    logic [25:0] pa_mem_line;
    logic [7:0]  pa_line_idx;
    logic [3:0]  pa_word;
    logic [1:0]  pa_size;
    logic        hit_dirty;
    logic [1:0]  hit_ref;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    xlat_buffer i_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_valid(fill_valid), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .hit(hit),
        .prot_fault(prot_fault), .page_fault(page_fault), .pa(pa),
        .pa_mem_line(pa_mem_line), .pa_line_idx(pa_line_idx),
        .pa_word(pa_word), .pa_size(pa_size), .hit_dirty(hit_dirty),
        .hit_ref(hit_ref)
    );

    // Row: {write, vaddr[63:0], code(0 hit,1 prot,2 page), pa[39:0], dirty, ref[1:0]}
    localparam logic [109:0] VEC [12] = '{
        {1'b0, 64'h0000_0000_0000_1123, 2'd0, 40'h0ABCDE1123, 1'b0, 2'd0},
        {1'b1, 64'h0000_0000_0000_1FFF, 2'd0, 40'h0ABCDE1FFF, 1'b0, 2'd1},
        {1'b0, 64'h0000_0000_0000_1000, 2'd0, 40'h0ABCDE1000, 1'b1, 2'd2},
        {1'b0, 64'h0000_0000_0000_1004, 2'd0, 40'h0ABCDE1004, 1'b1, 2'd3},
        {1'b0, 64'h0000_0000_0000_1FFC, 2'd0, 40'h0ABCDE1FFC, 1'b1, 2'd3},
        {1'b1, 64'hFFFF_FFFF_FFFF_FABC, 2'd0, 40'hFFFFFFFABC, 1'b0, 2'd0},
        {1'b0, 64'h1234_5678_9ABC_D040, 2'd1, 40'h0,          1'b0, 2'd0},
        {1'b1, 64'h0000_0000_0000_2010, 2'd2, 40'h0,          1'b0, 2'd0},
        {1'b0, 64'h0000_0000_0000_3000, 2'd2, 40'h0,          1'b0, 2'd0},
        {1'b0, 64'hFFFF_FFFF_FFFF_F000, 2'd0, 40'hFFFFFFF000, 1'b1, 2'd1},
        {1'b1, 64'h1234_5678_9ABC_DFFF, 2'd1, 40'h0,          1'b0, 2'd0},
        {1'b0, 64'h8000_0000_0000_1123, 2'd2, 40'h0,          1'b0, 2'd0}
    };

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive a lookup after the falling edge and let outputs settle.
    task automatic lookup(input logic wr, input logic [63:0] va);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_write = wr;
        lk_vaddr = va;
        #5;
    endtask

    // Write one slot through the refill port, no lookup alongside.
    task automatic fill(input logic [2:0] idx, input logic v, input logic r,
                        input logic w, input logic [51:0] vpn, input logic [27:0] ppn);
        @(negedge clk);
        lk_valid   = 1'b0;
        fill_en    = 1'b1;
        fill_idx   = idx;
        fill_valid = v;
        fill_rd    = r;
        fill_wr    = w;
        fill_vpn   = vpn;
        fill_ppn   = ppn;
        @(negedge clk);
        fill_en    = 1'b0;
    endtask

    // Check the three outcome outputs against an expected code.
    task automatic chk_outcome(input logic [1:0] code);
        string req;
        req = (code == 2'd0) ? "R3" : (code == 2'd1) ? "R5" : "R4";
        chk(req, "hit", 64'(hit), 64'(code == 2'd0));
        chk(req, "prot_fault", 64'(prot_fault), 64'(code == 2'd1));
        chk(req, "page_fault", 64'(page_fault), 64'(code == 2'd2));
    endtask

    // Check address, fields and pre-access status of a hit.
    task automatic chk_hit(input logic [39:0] epa, input logic ed, input logic [1:0] er);
        chk("R1", "pa", 64'(pa), 64'(epa));
        chk("R2", "pa_mem_line", 64'(pa_mem_line), 64'(epa[39:14]));
        chk("R2", "pa_line_idx", 64'(pa_line_idx), 64'(epa[13:6]));
        chk("R2", "pa_word", 64'(pa_word), 64'(epa[5:2]));
        chk("R2", "pa_size", 64'(pa_size), 64'(epa[1:0]));
        chk("R8", "hit_dirty", 64'(hit_dirty), 64'(ed));
        chk("R7", "hit_ref", 64'(hit_ref), 64'(er));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: empty after reset.
        lookup(1'b0, 64'h0000_0000_0000_1123);
        chk("R12", "page_fault after reset", 64'(page_fault), 64'd1);
        chk("R12", "hit after reset", 64'(hit), 64'd0);

        // Table setup.
        fill(3'd0, 1'b1, 1'b1, 1'b1, 52'h0_0000_0000_0001, 28'h0ABCDE1);
        fill(3'd1, 1'b1, 1'b1, 1'b0, 52'hF_FFFF_FFFF_FFFF, 28'hFFFFFFF);
        fill(3'd2, 1'b1, 1'b0, 1'b0, 52'h1_2345_6789_ABCD, 28'h0000001);
        fill(3'd3, 1'b0, 1'b1, 1'b1, 52'h0_0000_0000_0002, 28'h0000002);

        // Vector table walk.
        for (int k = 0; k < 12; k++) begin
            logic [109:0] v;
            v = VEC[k];
            lookup(v[109], v[108:45]);
            chk_outcome(v[44:43]);
            if (v[44:43] == 2'd0) begin
                chk_hit(v[42:3], v[2], v[1:0]);
            end else begin
                chk("R1", "pa zero without hit", 64'(pa), 64'd0);
            end
        end

        // R6: idle lookup raises nothing.
        @(negedge clk);
        lk_valid = 1'b0;
        lk_vaddr = 64'h0000_0000_0000_1123;
        #5;
        chk("R6", "idle outputs", 64'({hit, prot_fault, page_fault}), 64'd0);

        // R10: refill and write hit on slot 0 in one cycle; refill wins.
        @(negedge clk);
        lk_valid   = 1'b1;
        lk_write   = 1'b1;
        lk_vaddr   = 64'h0000_0000_0000_1040;
        fill_en    = 1'b1;
        fill_idx   = 3'd0;
        fill_valid = 1'b1;
        fill_rd    = 1'b1;
        fill_wr    = 1'b0;
        fill_vpn   = 52'h0_0000_0000_0001;
        fill_ppn   = 28'h1234567;
        @(negedge clk);
        fill_en  = 1'b0;
        lk_valid = 1'b0;
        lookup(1'b0, 64'h0000_0000_0000_1040);
        chk("R10", "hit after refill", 64'(hit), 64'd1);
        chk("R10", "new page number", 64'(pa), 64'h12_3456_7040);
        chk("R10", "dirty cleared", 64'(hit_dirty), 64'd0);
        chk("R10", "ref cleared", 64'(hit_ref), 64'd0);

        // R11: duplicate tag, lower slot has no permission.
        fill(3'd6, 1'b1, 1'b0, 1'b0, 52'h0_0000_0000_0077, 28'h6666666);
        fill(3'd7, 1'b1, 1'b1, 1'b0, 52'h0_0000_0000_0077, 28'h7777777);
        lookup(1'b1, 64'h0000_0000_0007_7010);
        chk("R11", "lower slot decides prot", 64'(prot_fault), 64'd1);
        chk("R11", "no hit from upper slot", 64'(hit), 64'd0);
        lookup(1'b1, 64'h0000_0000_0007_7020);
        chk("R11", "repeat prot", 64'(prot_fault), 64'd1);

        // R9: faulting writes left slot 7 untouched.
        fill(3'd6, 1'b0, 1'b0, 1'b0, 52'h0_0000_0000_0077, 28'h6666666);
        lookup(1'b0, 64'h0000_0000_0007_7abc);
        chk("R9", "hit via slot 7", 64'(hit), 64'd1);
        chk("R9", "slot 7 pa", 64'(pa), 64'h77_7777_7abc);
        chk("R9", "slot 7 dirty untouched", 64'(hit_dirty), 64'd0);
        chk("R9", "slot 7 ref untouched", 64'(hit_ref), 64'd0);
        lookup(1'b0, 64'h0000_0000_0007_7000);
        chk("R7", "ref stepped on slot 7", 64'(hit_ref), 64'd1);

        @(negedge clk);
        lk_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule